// File: doc/BRIEF.md
# Two-Slot Long-Word Execution Core

This block executes one long instruction word per valid cycle. Each word holds two independent register-to-register sub-instructions, one per slot, and both run in the same cycle against one shared sixteen-entry register file. Every operand read of both slots sees the register contents as they stood before the word. Neither slot can therefore observe the other slot's result within the same word. A program that needs such a dependency must place the two operations in separate words and pad the empty slots with no-ops.

Each slot supports four operations: no-op, OR with a zero-extended immediate, add and subtract. Register 0 is hardwired to zero. When both slots of one word target the same register, the later slot (slot 1) takes effect and a collision flag is raised for that cycle. A combinational debug port reads any register.

Top module: `vliw2_core`

## Requirements
- R1: Slot 0 sits in `word_in[31:0]` and slot 1 in `word_in[63:32]`. Within a 32-bit slot the fields are: opcode [31:30], destination [29:26], first source [25:22], second source [21:18], reserved [17:16], immediate [15:0]. The opcode values are 00 no-op, 01 OR-immediate, 10 add and 11 subtract. OR-immediate writes source1 OR the zero-extended immediate.
- R2: Add writes source1 + source2, modulo 2^32.
- R3: Subtract writes source1 - source2, modulo 2^32.
- R4: A no-op slot changes no register. A word presented with `word_valid` low changes no register, whatever it holds.
- R5: Both slots read the register values from before the word. With r2=6 and r3=4, the word {add r2,r2,r3 ; sub r4,r2,r3} leaves r2=10 and r4=2. Issued as two separate words with no-op padding, the same operations leave r4=6.
- R6: If both slots write the same nonzero register, slot 1's value is stored, and `wr_conflict` is 1 in that same cycle (combinationally, while `word_valid` is high).
- R7: Register 0 always reads as zero, and writes to it are dropped.
- R8: Register writes of a valid word become visible on `dbg_data` after the rising clock edge that ends the cycle in which the word is valid. A synchronous active-low reset clears every register to zero.
- R9: `wr_conflict` is 0 when the destinations differ, when either slot is a no-op, when the shared destination is register 0, or when `word_valid` is low.
- R10: A slot whose reserved bits [17:16] are not both zero executes as a no-op.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| word_valid | input | 1 | Word on `word_in` is executed this cycle |
| word_in | input | 64 | Long instruction word, slot 1 in the upper half |
| dbg_addr | input | 4 | Register index for the debug read |
| dbg_data | output | 32 | Current contents of register `dbg_addr` |
| wr_conflict | output | 1 | Both slots write the same nonzero register this cycle |

## Verification
`wr_conflict` is combinational, so it is due in the same cycle the word is presented. The bench samples it 1 ns after driving the word on the falling edge, which is before the rising edge that commits the word. Register results are due one rising edge later. The bench therefore reads all sixteen registers through the combinational debug port at the following falling edge, with `word_valid` already low, and compares them with a bench-side model. That model takes all operands from the pre-word state and applies slot 1 last.

// File: rtl/vliw2_pkg.sv
// Shared types for the two-slot core: opcode encoding, decoded slot record
// and the field layout of one 32-bit sub-instruction.
package vliw2_pkg;
    localparam int SLOT_W = 32;
    localparam int REG_AW = 4;
    localparam int IMM_W  = 16;

    typedef enum logic [1:0] {
        OP_NOP = 2'b00,
        OP_ORI = 2'b01,
        OP_ADD = 2'b10,
        OP_SUB = 2'b11
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [REG_AW-1:0] rd;
        logic [REG_AW-1:0] rs;
        logic [REG_AW-1:0] rt;
        logic [1:0]        rsv;
        logic [IMM_W-1:0]  imm;
    } slot_t;

    // Split a raw sub-instruction; a nonzero reserved field turns it into a no-op.
    function automatic slot_t decode_slot(input logic [SLOT_W-1:0] raw);
        slot_t s;
        s = slot_t'(raw);
        if (s.rsv != 2'b00) s.op = OP_NOP;
        return s;
    endfunction
endpackage

// File: rtl/vliw2_alu.sv
// One slot's execution unit: purely combinational.
// Assumes IMM_W <= DATA_W; the immediate is zero-extended.
module vliw2_alu
    import vliw2_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] result,
    output logic              writes
);
    localparam int PAD_W = DATA_W - IMM_W;

    // Select the operation result and whether it targets the register file.
    always_comb begin
        writes = 1'b1;
        unique case (op)
            OP_ORI:  result = src_a | {{PAD_W{1'b0}}, imm};
            OP_ADD:  result = src_a + src_b;
            OP_SUB:  result = src_a - src_b;
            default: begin
                result = '0;
                writes = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/vliw2_regfile.sv
// Register file with NRD combinational read ports and two write ports.
// Write port 1 has priority over port 0 on the same address. Address 0 is
// never written and always reads zero. Synchronous active-low reset.
module vliw2_regfile #(
    parameter int DATA_W = 32,
    parameter int NREG   = 16,
    parameter int NRD    = 5,
    localparam int AW    = $clog2(NREG)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NRD-1:0][AW-1:0]       raddr,
    output logic [NRD-1:0][DATA_W-1:0]   rdata,
    input  logic [1:0]                   we,
    input  logic [1:0][AW-1:0]           waddr,
    input  logic [1:0][DATA_W-1:0]       wdata
);
    logic [NREG-1:0][DATA_W-1:0] mem;

    // Commit both write ports; the later loop pass (port 1) wins on a tie.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else begin
            for (int k = 0; k < 2; k++) begin
                if (we[k] && waddr[k] != '0) mem[waddr[k]] <= wdata[k];
            end
        end
    end

    // Read ports: address 0 forced to zero.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = (raddr[p] == '0) ? '0 : mem[raddr[p]];
    end

    // R7: register 0 never holds a value.
    p_zero_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem[0] == '0);

    // R4: no write enable means the whole file is unchanged at the next edge.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we == 2'b00) |=> $stable(mem));

    // R6: port 1 data lands in its register.
    p_port1_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we[1] && waddr[1] != '0) |=> (mem[$past(waddr[1])] == $past(wdata[1])));

    // R8: port 0 data lands when port 1 does not collide with it.
    p_port0_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we[0] && waddr[0] != '0 && !(we[1] && waddr[1] == waddr[0]))
        |=> (mem[$past(waddr[0])] == $past(wdata[0])));
endmodule

// File: rtl/vliw2_core.sv
// Two-slot long-word core. Each valid cycle both sub-instructions are
// decoded, read their operands from the pre-word register state, execute,
// and commit on the closing rising edge. Slot 1 overrides slot 0 on a
// shared destination, signalled on wr_conflict. Assumes DATA_W >= IMM_W.
module vliw2_core
    import vliw2_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NREG   = 16,
    localparam int NSLOT = 2,
    localparam int NRD   = 2 * NSLOT + 1,
    localparam int DBG   = NRD - 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      word_valid,
    input  logic [NSLOT*SLOT_W-1:0]   word_in,
    input  logic [REG_AW-1:0]         dbg_addr,
    output logic [DATA_W-1:0]         dbg_data,
    output logic                      wr_conflict
);
    slot_t                          slot   [NSLOT];
    logic [NRD-1:0][REG_AW-1:0]     raddr;
    logic [NRD-1:0][DATA_W-1:0]     rdata;
    logic [NSLOT-1:0]               alu_wr;
    logic [NSLOT-1:0]               we;
    logic [NSLOT-1:0][REG_AW-1:0]   waddr;
    logic [NSLOT-1:0][DATA_W-1:0]   wdata;

    // Per-slot decode, operand fetch and execution.
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign slot[s]        = decode_slot(word_in[s*SLOT_W +: SLOT_W]);
        assign raddr[2*s]     = slot[s].rs;
        assign raddr[2*s + 1] = slot[s].rt;
        assign waddr[s]       = slot[s].rd;
        assign we[s]          = word_valid && alu_wr[s];

        vliw2_alu #(.DATA_W(DATA_W)) u_alu (
            .op     (slot[s].op),
            .src_a  (rdata[2*s]),
            .src_b  (rdata[2*s + 1]),
            .imm    (slot[s].imm),
            .result (wdata[s]),
            .writes (alu_wr[s])
        );

        // R4, R10: a no-op or reserved-bit slot, or an invalid word, never writes.
        p_nop_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!word_valid || word_in[s*SLOT_W + 30 +: 2] == 2'b00
             || word_in[s*SLOT_W + 16 +: 2] != 2'b00) |-> !we[s]);

        // R1: an OR-immediate result only sets bits from source or immediate.
        p_ori_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (slot[s].op == OP_ORI) |->
            ((wdata[s] & ~rdata[2*s] & ~{{(DATA_W-IMM_W){1'b0}}, slot[s].imm}) == '0));
    end

    assign raddr[DBG] = dbg_addr;
    assign dbg_data   = rdata[DBG];

    // Collision detect: both slots write one nonzero register this cycle.
    assign wr_conflict = we[0] && we[1] && (waddr[0] == waddr[1]) && (waddr[0] != '0);

    vliw2_regfile #(.DATA_W(DATA_W), .NREG(NREG), .NRD(NRD)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr (raddr),
        .rdata (rdata),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata)
    );

    // R9: the flag never rises without a valid word.
    p_conflict_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_conflict |-> word_valid);

    // R7: the debug port shows zero for register 0.
    p_dbg_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_addr == '0) |-> (dbg_data == '0));
endmodule

// File: tb/vliw2_core_test.sv
`timescale 1ns/1ps
// Self-checking bench: directed cases plus a sweep over every opcode pair.
module vliw2_core_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        word_valid;
    logic [63:0] word_in;
    logic [3:0]  dbg_addr;
    logic [31:0] dbg_data;
    logic        wr_conflict;

    int          vectors = 0;
    int          miscompares = 0;
    logic [31:0] model [16];
    logic [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;

    vliw2_core uut (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_in(word_in),
        .dbg_addr(dbg_addr), .dbg_data(dbg_data), .wr_conflict(wr_conflict)
    );

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [31:0] enc(input logic [1:0] op, input logic [3:0] rd,
        input logic [3:0] rs, input logic [3:0] rt, input logic [15:0] imm,
        input logic [1:0] rsv = 2'b00);
        return {op, rd, rs, rt, rsv, imm};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic verify_all(input string tag);
        for (int i = 0; i < 16; i++) begin
            dbg_addr = 4'(i);
            #0.5;
            check(tag, dbg_data, model[i]);
        end
    endtask

    // Apply one word for one cycle, check the flag in-cycle, registers after the edge.
    task automatic run_word(input logic [63:0] w, input logic valid, input string tag);
        logic [31:0] nxt [16];
        logic [31:0] sl;
        logic [31:0] a, b, r;
        logic        wr [2];
        logic [3:0]  rd [2];
        @(negedge clk);
        word_in = w;
        word_valid = valid;
        #1;
        nxt = model;
        for (int s = 0; s < 2; s++) begin
            sl = w[s*32 +: 32];
            rd[s] = sl[29:26];
            a = model[sl[25:22]];
            b = model[sl[21:18]];
            wr[s] = valid && sl[31:30] != 2'b00 && sl[17:16] == 2'b00;
            case (sl[31:30])
                2'b01:   r = a | {16'h0, sl[15:0]};
                2'b10:   r = a + b;
                default: r = a - b;
            endcase
            if (wr[s] && rd[s] != 4'd0) nxt[rd[s]] = r;
        end
        check({tag, " R6 R9 conflict"}, {31'b0, wr_conflict},
              {31'b0, wr[0] && wr[1] && rd[0] == rd[1] && rd[0] != 4'd0});
        @(posedge clk);
        @(negedge clk);
        word_valid = 1'b0;
        model = nxt;
        verify_all(tag);
    endtask

    initial begin
        #(20 * 200000);
        miscompares++;
        $display("FAIL watchdog R8 actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        word_valid = 1'b0;
        word_in = '0;
        dbg_addr = '0;
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        verify_all("R8 reset");

        // R5: dependent pair in one word versus split with no-op padding.
        run_word({enc(2'b01, 4'd3, 4'd0, 4'd0, 16'd4), enc(2'b01, 4'd2, 4'd0, 4'd0, 16'd6)}, 1'b1, "R1 load");
        run_word({enc(2'b11, 4'd4, 4'd2, 4'd3, 16'd0), enc(2'b10, 4'd2, 4'd2, 4'd3, 16'd0)}, 1'b1, "R5 same word");
        check("R5 r2", model[2], 32'd10);
        check("R5 r4", model[4], 32'd2);
        run_word({enc(2'b01, 4'd3, 4'd0, 4'd0, 16'd4), enc(2'b01, 4'd2, 4'd0, 4'd0, 16'd6)}, 1'b1, "R1 reload");
        run_word({32'h0, enc(2'b10, 4'd2, 4'd2, 4'd3, 16'd0)}, 1'b1, "R2 split add");
        run_word({enc(2'b11, 4'd4, 4'd2, 4'd3, 16'd0), 32'h0}, 1'b1, "R3 split sub");
        check("R5 split r4", model[4], 32'd6);

        // R6: same destination, slot 1 wins.
        run_word({enc(2'b01, 4'd5, 4'd0, 4'd0, 16'd2), enc(2'b01, 4'd5, 4'd0, 4'd0, 16'd1)}, 1'b1, "R6 collide");
        check("R6 r5", model[5], 32'd2);
        // R7: writes to register 0 are dropped, no flag.
        run_word({enc(2'b01, 4'd0, 4'd0, 4'd0, 16'hBEEF), enc(2'b01, 4'd0, 4'd5, 4'd0, 16'hFFFF)}, 1'b1, "R7 r0");
        // R4: invalid word ignored.
        run_word({enc(2'b01, 4'd7, 4'd0, 4'd0, 16'h5A5A), enc(2'b10, 4'd7, 4'd2, 4'd2, 16'd0)}, 1'b0, "R4 invalid");
        // R10: reserved bits set turn a slot into a no-op.
        run_word({enc(2'b01, 4'd8, 4'd0, 4'd0, 16'h0077, 2'b10), enc(2'b01, 4'd8, 4'd0, 4'd0, 16'h0011, 2'b01)}, 1'b1, "R10 reserved");
        // R3: subtract wraps below zero.
        run_word({32'h0, enc(2'b11, 4'd9, 4'd0, 4'd2, 16'd0)}, 1'b1, "R3 wrap");
        check("R3 wrap value", model[9], 32'hFFFF_FFF6);

        // Sweep every opcode pair with random fields; every fourth word shares rd.
        for (int o0 = 0; o0 < 4; o0++) begin
            for (int o1 = 0; o1 < 4; o1++) begin
                for (int rep = 0; rep < 40; rep++) begin
                    logic [31:0] x, y;
                    x = rnd();
                    y = rnd();
                    if (rep % 4 == 0) y[29:26] = x[29:26];
                    run_word({enc(2'(o1), y[29:26], y[25:22], y[21:18], y[15:0]),
                              enc(2'(o0), x[29:26], x[25:22], x[21:18], x[15:0])},
                             1'b1, "sweep R1 R2 R3 R4 R6 R7");
                end
            end
        end

        // R8: reset after activity clears everything.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) model[i] = '0;
        verify_all("R8 re-reset");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule